// File: doc/BRIEF.md
# Bus Command Channel Engine

This block is one register-mapped command channel for a serial power-management bus. A host places up to eight outgoing bytes in two 32-bit data words, then writes a command word. That write starts a transaction on a simplified downstream request/acknowledge interface. When the downstream side answers, the engine records the outcome in a status register. For read-type commands it also stores the returned bytes in two read-data words.

The channel's registers sit in a 128-byte window. Window n begins at byte address 0x800 + 0x80 * n, and the parameter `CHAN_IDX` picks n. Before it starts a transaction, the engine checks a downstream permission input. A refused request, or an opcode with no defined meaning, completes at once and touches nothing on the bus.

Top module: `cmd_chan_engine`

## Requirements
- R1: The channel answers only byte addresses from 0x800 + 0x80 * CHAN_IDX up to 0x7F above that. Inside the window the offsets are: command 0x00, configuration 0x04, status 0x08, outgoing data low/high 0x10/0x14, and incoming data low/high 0x18/0x1C. Any other address reads 0, and writes to it change nothing.
- R2: The command word carries the opcode in [31:27], the slave ID in [23:20], the 16-bit register address in [19:4] and the byte count minus one in [2:0]. An accepted command presents these on bus_opcode, bus_sid, bus_addr and bus_len. Reading offset 0x00 returns the last accepted command word.
- R3: The control opcodes 3, 4, 5 and 6 drive zero on bus_addr, bus_len and bus_wdata.
- R4: Every defined opcode other than the read opcodes (1, 8, 13, 15) and the control opcodes carries write data. bus_wdata[31:0] holds the low outgoing data word and bus_wdata[63:32] the high one, with byte k in bits [8k+7:8k]. Byte k is zero when k exceeds the count field.
- R5: A read opcode that completes with neither bus_fail nor bus_drop stores bus_rdata into the incoming data words, with the same byte placement as R4. Bytes beyond the count are zeroed.
- R6: An accepted command clears the status register. In the next cycle bus_req rises, and it stays high with bus fields unchanged until the cycle in which bus_ack is sampled.
- R7: Status is {dropped, denied, failure, done} in bits [3:0]. The edge that samples bus_ack high lowers bus_req and sets done, with failure = bus_fail and dropped = bus_drop.
- R8: A command write while a transaction is outstanding is ignored.
- R9: If bus_permit is low when a command is written, the command completes in the next cycle with status 0x5 (done and denied) and never raises bus_req. This check takes priority over R10.
- R10: Opcodes 10, 11, 12 and 17 to 31 complete in the next cycle with status 0x3 (done and failure) and never raise bus_req.
- R11: The configuration word is plain read/write storage. Writes to status and to the incoming data words are ignored.
- R12: A read that completes with failure or dropped leaves the incoming data words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 12 | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr (combinational) |
| bus_permit | input | 1 | Downstream grants this channel access |
| bus_req | output | 1 | Transaction outstanding |
| bus_opcode | output | 5 | Opcode of the outstanding transaction |
| bus_sid | output | 4 | Slave ID |
| bus_addr | output | 16 | Register address on the slave |
| bus_len | output | 3 | Byte count minus one |
| bus_wdata | output | 64 | Outgoing bytes, byte k at bits [8k+7:8k] |
| bus_ack | input | 1 | Downstream response valid |
| bus_fail | input | 1 | Response reports failure |
| bus_drop | input | 1 | Response reports a dropped transaction |
| bus_rdata | input | 64 | Returned bytes, byte k at bits [8k+7:8k] |

## Verification
The bench crosses all 32 opcode codes with all eight byte counts. Each vector uses different data, address and slave ID, so a misplaced field, a byte-mask error at any boundary, or a control opcode that leaks fields to the bus shows up on the outputs. Response latency, failure, drop and refused permission are varied arithmetically across the sweep. This separates completion on success, on error and without bus access, and it catches a failed read that overwrites earlier data. Separate sequences write other channels' windows, write read-only offsets, and issue commands while a transaction is outstanding.

// File: rtl/cce_pkg.sv
// Shared definitions for the bus command channel engine.
// Assumes 32-bit host registers and an 8-byte bus data path.
package cce_pkg;

    localparam int WORD_W = 32;
    localparam int NBYTES = 8;
    localparam int CNT_W  = $clog2(NBYTES);
    localparam int BUS_W  = 8 * NBYTES;

    // Offsets inside one channel window
    localparam int OFS_CMD  = 'h00;
    localparam int OFS_CFG  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_WLO  = 'h10;
    localparam int OFS_WHI  = 'h14;
    localparam int OFS_RLO  = 'h18;
    localparam int OFS_RHI  = 'h1C;

    typedef enum logic [4:0] {
        OP_XWRL = 5'd0,  OP_XRDL = 5'd1,  OP_XWR  = 5'd2,  OP_RST  = 5'd3,
        OP_SLP  = 5'd4,  OP_SHDN = 5'd5,  OP_WAKE = 5'd6,  OP_AUTH = 5'd7,
        OP_MRD  = 5'd8,  OP_MWR  = 5'd9,  OP_XRD  = 5'd13, OP_WR   = 5'd14,
        OP_RD   = 5'd15, OP_ZWR  = 5'd16
    } cce_op_e;

    typedef enum logic [1:0] {
        OPK_WRITE = 2'd0,
        OPK_READ  = 2'd1,
        OPK_CTRL  = 2'd2,
        OPK_BAD   = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic dropped;
        logic denied;
        logic failure;
        logic done;
    } cce_stat_t;

    // Classify a raw 5-bit opcode
    function automatic op_kind_e op_kind(input logic [4:0] op);
        case (op)
            OP_XRDL, OP_MRD, OP_XRD, OP_RD:                   op_kind = OPK_READ;
            OP_RST, OP_SLP, OP_SHDN, OP_WAKE:                 op_kind = OPK_CTRL;
            OP_XWRL, OP_XWR, OP_AUTH, OP_MWR, OP_WR, OP_ZWR:  op_kind = OPK_WRITE;
            default:                                          op_kind = OPK_BAD;
        endcase
    endfunction

endpackage

// File: rtl/cce_regwin.sv
// Host register window of one channel.
// Decodes the window, holds the configuration and outgoing data words,
// produces the command-write strobe and muxes read data.
// Assumes WIN_SPAN is a power of two.
module cce_regwin
    import cce_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WIN_BASE = 'h900,
    parameter int WIN_SPAN = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] cmd_last,
    input  cce_stat_t         stat,
    input  logic [BUS_W-1:0]  rd_bytes,
    output logic              cmd_wr,
    output logic [BUS_W-1:0]  wr_bytes
);

    localparam int OFS_W = $clog2(WIN_SPAN);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WIN_SPAN);

    logic [ADDR_W-1:0] rel;
    logic              hit;
    logic [OFS_W-1:0]  ofs;
    logic [WORD_W-1:0] cfg_q, wlo_q, whi_q;

    // Window hit and offset inside the window
    assign rel = reg_addr - BASE_A;
    assign hit = (reg_addr >= BASE_A) && (rel < SPAN_A);
    assign ofs = rel[OFS_W-1:0];

    assign cmd_wr   = reg_wr && hit && (ofs == OFS_W'(OFS_CMD));
    assign wr_bytes = {whi_q, wlo_q};

    // Writable storage: configuration and outgoing data words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            wlo_q <= '0;
            whi_q <= '0;
        end else if (reg_wr && hit) begin
            if (ofs == OFS_W'(OFS_CFG)) cfg_q <= reg_wdata;
            if (ofs == OFS_W'(OFS_WLO)) wlo_q <= reg_wdata;
            if (ofs == OFS_W'(OFS_WHI)) whi_q <= reg_wdata;
        end
    end

    // Read mux over the window
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (ofs)
                OFS_W'(OFS_CMD):  reg_rdata = cmd_last;
                OFS_W'(OFS_CFG):  reg_rdata = cfg_q;
                OFS_W'(OFS_STAT): reg_rdata = {{(WORD_W-4){1'b0}}, stat};
                OFS_W'(OFS_WLO):  reg_rdata = wlo_q;
                OFS_W'(OFS_WHI):  reg_rdata = whi_q;
                OFS_W'(OFS_RLO):  reg_rdata = rd_bytes[WORD_W-1:0];
                OFS_W'(OFS_RHI):  reg_rdata = rd_bytes[BUS_W-1:WORD_W];
                default:          reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cce_decode.sv
// Command decode: classifies the opcode and forms the bus address, length
// and byte-masked write data that a command would issue.
// Purely combinational; the sequencer latches the results.
module cce_decode
    import cce_pkg::*;
(
    input  logic [4:0]       op,
    input  logic [CNT_W-1:0] cnt,
    input  logic [15:0]      raddr,
    input  logic [BUS_W-1:0] wr_bytes,
    output op_kind_e         kind,
    output logic [15:0]      addr_d,
    output logic [CNT_W-1:0] len_d,
    output logic [BUS_W-1:0] wdata_d
);

    logic [NBYTES-1:0] keep;

    // Opcode class
    assign kind = op_kind(op);

    // Control commands carry no address or count
    assign addr_d = (kind == OPK_CTRL) ? 16'h0000 : raddr;
    assign len_d  = (kind == OPK_CTRL) ? '0 : cnt;

    // Per-byte keep mask and write-data gating
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign keep[b] = (CNT_W'(b) <= cnt);
        assign wdata_d[8*b +: 8] = (kind == OPK_WRITE && keep[b]) ? wr_bytes[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/cce_seq.sv
// Transaction sequencer: accepts a command when idle, resolves denied and
// undefined commands at once, otherwise holds a bus request until the
// acknowledge, then records status and captures read bytes.
// Assumes bus_ack is only meaningful while bus_req is high.
module cce_seq
    import cce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    input  op_kind_e          kind,
    input  logic [15:0]       addr_d,
    input  logic [CNT_W-1:0]  len_d,
    input  logic [BUS_W-1:0]  wdata_d,
    input  logic              bus_permit,
    input  logic              bus_ack,
    input  logic              bus_fail,
    input  logic              bus_drop,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              cmd_accept,
    output logic              bus_req,
    output logic [4:0]        bus_opcode,
    output logic [3:0]        bus_sid,
    output logic [15:0]       bus_addr,
    output logic [CNT_W-1:0]  bus_len,
    output logic [BUS_W-1:0]  bus_wdata,
    output cce_stat_t         stat,
    output logic [BUS_W-1:0]  rd_bytes,
    output logic [WORD_W-1:0] cmd_last
);

    typedef enum logic {ST_IDLE, ST_BUSY} st_e;

    st_e               st_q;
    logic              is_rd_q;
    logic [BUS_W-1:0]  rd_masked;

    assign cmd_accept = cmd_wr && (st_q == ST_IDLE);
    assign bus_req    = (st_q == ST_BUSY);

    // Returned bytes beyond the count are forced to zero
    for (genvar b = 0; b < NBYTES; b++) begin : g_rmask
        assign rd_masked[8*b +: 8] = (CNT_W'(b) <= bus_len) ? bus_rdata[8*b +: 8] : 8'h00;
    end

    // State, latched bus fields, status and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            is_rd_q    <= 1'b0;
            bus_opcode <= '0;
            bus_sid    <= '0;
            bus_addr   <= '0;
            bus_len    <= '0;
            bus_wdata  <= '0;
            stat       <= '0;
            rd_bytes   <= '0;
            cmd_last   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_accept) begin
                        cmd_last <= cmd_word;
                        stat     <= '0;
                        if (!bus_permit) begin
                            stat.done   <= 1'b1;
                            stat.denied <= 1'b1;
                        end else if (kind == OPK_BAD) begin
                            stat.done    <= 1'b1;
                            stat.failure <= 1'b1;
                        end else begin
                            st_q       <= ST_BUSY;
                            is_rd_q    <= (kind == OPK_READ);
                            bus_opcode <= cmd_word[31:27];
                            bus_sid    <= cmd_word[23:20];
                            bus_addr   <= addr_d;
                            bus_len    <= len_d;
                            bus_wdata  <= wdata_d;
                        end
                    end
                end
                ST_BUSY: begin
                    if (bus_ack) begin
                        st_q         <= ST_IDLE;
                        stat.done    <= 1'b1;
                        stat.failure <= bus_fail;
                        stat.dropped <= bus_drop;
                        if (is_rd_q && !bus_fail && !bus_drop) rd_bytes <= rd_masked;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmd_chan_engine.sv
// Top of one bus command channel: register window, command decode and
// transaction sequencer. CHAN_IDX selects which window of the channel
// array this instance answers.
module cmd_chan_engine
    import cce_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int WIN_FIRST  = 'h800,
    parameter int WIN_STRIDE = 'h80,
    parameter int CHAN_IDX   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bus_permit,
    output logic              bus_req,
    output logic [4:0]        bus_opcode,
    output logic [3:0]        bus_sid,
    output logic [15:0]       bus_addr,
    output logic [2:0]        bus_len,
    output logic [63:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_fail,
    input  logic              bus_drop,
    input  logic [63:0]       bus_rdata
);

    localparam int WIN_BASE = WIN_FIRST + WIN_STRIDE * CHAN_IDX;

    logic              cmd_wr;
    logic              cmd_accept;
    logic [BUS_W-1:0]  wr_bytes;
    logic [BUS_W-1:0]  rd_bytes;
    logic [WORD_W-1:0] cmd_last;
    cce_stat_t         stat_q;
    op_kind_e          kind;
    logic [15:0]       addr_d;
    logic [CNT_W-1:0]  len_d;
    logic [BUS_W-1:0]  wdata_d;

    cce_regwin #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_SPAN(WIN_STRIDE)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cmd_last (cmd_last),
        .stat     (stat_q),
        .rd_bytes (rd_bytes),
        .cmd_wr   (cmd_wr),
        .wr_bytes (wr_bytes)
    );

    cce_decode u_dec (
        .op      (reg_wdata[31:27]),
        .cnt     (reg_wdata[2:0]),
        .raddr   (reg_wdata[19:4]),
        .wr_bytes(wr_bytes),
        .kind    (kind),
        .addr_d  (addr_d),
        .len_d   (len_d),
        .wdata_d (wdata_d)
    );

    cce_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_word  (reg_wdata),
        .kind      (kind),
        .addr_d    (addr_d),
        .len_d     (len_d),
        .wdata_d   (wdata_d),
        .bus_permit(bus_permit),
        .bus_ack   (bus_ack),
        .bus_fail  (bus_fail),
        .bus_drop  (bus_drop),
        .bus_rdata (bus_rdata),
        .cmd_accept(cmd_accept),
        .bus_req   (bus_req),
        .bus_opcode(bus_opcode),
        .bus_sid   (bus_sid),
        .bus_addr  (bus_addr),
        .bus_len   (bus_len),
        .bus_wdata (bus_wdata),
        .stat      (stat_q),
        .rd_bytes  (rd_bytes),
        .cmd_last  (cmd_last)
    );

endmodule

// File: rtl/cce_checker.sv
// Protocol and status properties of the command channel, bound to the top.
// Assumes stat bits are {dropped, denied, failure, done}.
module cce_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_accept,
    input logic       bus_permit,
    input logic       bus_req,
    input logic       bus_ack,
    input logic [4:0] bus_opcode,
    input logic [2:0] bus_len,
    input logic [3:0] stat
);

    // R6: request held until acknowledged
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req);

    // R6: status is clear when a request starts
    a_r6_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> stat == 4'b0000);

    // R8: outstanding transaction fields stay fixed
    a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> $stable(bus_opcode) && $stable(bus_len));

    // R7: acknowledge ends the request with done
    a_r7_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req && stat[0]);

    // R7: error flags only appear with done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[3:1] != 3'b000) |-> stat[0]);

    // R9: refused permission completes at once without a request
    a_r9_denied: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept && !bus_permit |=> !bus_req && stat == 4'b0101);

endmodule

bind cmd_chan_engine cce_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_accept(cmd_accept),
    .bus_permit(bus_permit),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_opcode(bus_opcode),
    .bus_len   (bus_len),
    .stat      (stat_q)
);

// File: tb/cmd_chan_engine_tb.sv
// Sweep bench: every opcode code against every byte count, with varied
// latency and outcome, plus window, read-only and busy sequences.
module cmd_chan_engine_tb_top;

    localparam int BASE = 'h900;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_permit = 1'b1;
    logic        bus_req;
    logic [4:0]  bus_opcode;
    logic [3:0]  bus_sid;
    logic [15:0] bus_addr;
    logic [2:0]  bus_len;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_fail = 1'b0;
    logic        bus_drop = 1'b0;
    logic [63:0] bus_rdata = '0;

    int vectors = 0;
    int fails = 0;
    bit done_flag = 0;
    logic [63:0] exp_rd = '0;

    always #5 clk = ~clk;

    cmd_chan_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_permit(bus_permit),
        .bus_req(bus_req), .bus_opcode(bus_opcode), .bus_sid(bus_sid),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_fail(bus_fail), .bus_drop(bus_drop),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] mask_bytes(input logic [63:0] v, input int cnt);
        logic [63:0] r = '0;
        for (int i = 0; i < 8; i++) if (i <= cnt) r[8*i +: 8] = v[8*i +: 8];
        return r;
    endfunction

    function automatic int kind_of(input int op);
        if (op == 1 || op == 8 || op == 13 || op == 15) return 1;   // read
        if (op >= 3 && op <= 6) return 2;                           // control
        if (op <= 9 || op == 14 || op == 16) return 0;              // write
        return 3;                                                   // undefined
    endfunction

    // One command with a bench-side bus responder
    task automatic run_cmd(input int op, input int cnt, input int dly,
                           input bit permit, input bit fl, input bit dr);
        logic [31:0] wlo, whi, cw, v;
        logic [15:0] ad;
        logic [3:0]  sid;
        logic [63:0] resp;
        int k;
        k   = kind_of(op);
        wlo = 32'h11223344 + op * 32'h01010101 + cnt;
        whi = ~wlo ^ (cnt << 9);
        ad  = 16'((op << 8) | (cnt << 4) | 4'hC) ^ 16'h8001;
        sid = 4'((op + cnt) % 16);
        cw  = {5'(op), 3'b000, sid, ad, 1'b0, 3'(cnt)};
        resp = {wlo ^ 32'h5A5A5A5A, whi ^ 32'h3C3C3C3C};
        wr(12'(BASE + 'h10), wlo);
        wr(12'(BASE + 'h14), whi);
        bus_permit = permit;
        wr(12'(BASE), cw);
        bus_permit = 1'b1;
        rd(12'(BASE), v);
        chk("R2 cmd readback", v, cw);
        if (!permit) begin
            chk("R9 no req", bus_req, 0);
            rd(12'(BASE + 'h08), v);
            chk("R9 denied status", v, 32'h5);
            return;
        end
        if (k == 3) begin
            chk("R10 no req", bus_req, 0);
            rd(12'(BASE + 'h08), v);
            chk("R10 undefined status", v, 32'h3);
            return;
        end
        chk("R6 req", bus_req, 1);
        rd(12'(BASE + 'h08), v);
        chk("R6 status cleared", v, 0);
        chk("R2 opcode", bus_opcode, 64'(op));
        chk("R2 sid", bus_sid, sid);
        chk("R3 addr", bus_addr, (k == 2) ? 0 : ad);
        chk("R3 len", bus_len, (k == 2) ? 0 : cnt);
        chk("R4 wdata", bus_wdata, (k == 0) ? mask_bytes({whi, wlo}, cnt) : 64'h0);
        for (int i = 0; i < dly; i++) begin
            @(posedge clk); #1;
            chk("R6 req held", bus_req, 1);
        end
        bus_ack = 1'b1; bus_fail = fl; bus_drop = dr; bus_rdata = resp;
        @(posedge clk); #1;
        bus_ack = 1'b0; bus_fail = 1'b0; bus_drop = 1'b0; bus_rdata = '0;
        chk("R7 req low", bus_req, 0);
        rd(12'(BASE + 'h08), v);
        chk("R7 status", v, {28'h0, dr, 1'b0, fl, 1'b1});
        if (k == 1 && !fl && !dr) exp_rd = mask_bytes(resp, cnt);
        rd(12'(BASE + 'h18), v);
        chk((k == 1 && (fl || dr)) ? "R12 rdata lo" : "R5 rdata lo", v, exp_rd[31:0]);
        rd(12'(BASE + 'h1C), v);
        chk((k == 1 && (fl || dr)) ? "R12 rdata hi" : "R5 rdata hi", v, exp_rd[63:32]);
    endtask

    // Watchdog
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R7 reset req", bus_req, 0);
        rd(12'(BASE + 'h08), v);  chk("R7 reset status", v, 0);
        rd(12'(BASE + 'h18), v);  chk("R5 reset rdata", v, 0);

        // R11: config storage, read-only status and incoming data
        wr(12'(BASE + 'h04), 32'hCAFE0123);
        rd(12'(BASE + 'h04), v);  chk("R11 config", v, 32'hCAFE0123);
        wr(12'(BASE + 'h08), 32'hFFFFFFFF);
        rd(12'(BASE + 'h08), v);  chk("R11 status ro", v, 0);
        wr(12'(BASE + 'h18), 32'hFFFFFFFF);
        rd(12'(BASE + 'h18), v);  chk("R11 rdata ro", v, 0);

        // R1: other windows and unmapped offsets
        wr(12'h884, 32'h12345678);
        wr(12'h984, 32'h87654321);
        rd(12'(BASE + 'h04), v);  chk("R1 config untouched", v, 32'hCAFE0123);
        rd(12'h884, v);           chk("R1 lower window", v, 0);
        rd(12'h984, v);           chk("R1 upper window", v, 0);
        rd(12'(BASE + 'h0C), v);  chk("R1 hole", v, 0);
        wr(12'h880, {5'd14, 27'h0});
        chk("R1 foreign cmd", bus_req, 0);

        // Sweep opcode x count
        for (int op = 0; op < 32; op++) begin
            for (int cnt = 0; cnt < 8; cnt++) begin
                int s;
                s = op * 8 + cnt;
                run_cmd(op, cnt, s % 4, (s % 13) != 6, (s % 7) == 3, (s % 11) == 5);
            end
        end

        // R8: command write while busy is ignored
        wr(12'(BASE), {5'd14, 3'b0, 4'h3, 16'h0042, 1'b0, 3'd1});
        chk("R8 busy start", bus_req, 1);
        wr(12'(BASE), {5'd15, 3'b0, 4'h9, 16'h0777, 1'b0, 3'd7});
        chk("R8 opcode kept", bus_opcode, 14);
        chk("R8 addr kept", bus_addr, 16'h0042);
        rd(12'(BASE), v);
        chk("R8 cmd readback kept", v, {5'd14, 3'b0, 4'h3, 16'h0042, 1'b0, 3'd1});
        bus_ack = 1'b1;
        @(posedge clk); #1;
        bus_ack = 1'b0;
        rd(12'(BASE + 'h08), v);  chk("R8 status", v, 1);
        chk("R8 idle after", bus_req, 0);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule